// File: doc/BRIEF.md
# Multiplexed Scan Chain with Built-in Test Sequencer

This block holds the state register of a sequential design as a chain of flip-flops. Each flip-flop has a 2:1 selector in front of it. In functional operation every flip-flop takes the next-state vector computed by the surrounding combinational logic. In shift operation the flip-flops form one serial register, so the state register can be written and read bit by bit. The present-state vector drives the surrounding logic as its pseudo-inputs, and the next-state vector comes back as its pseudo-outputs. Testing the sequential design therefore reduces to testing its combinational part.

A built-in sequencer runs the complete test on its own. It first pushes an alternating bit stream through the chain and compares what comes out at the far end. It then shifts in the first stimulus and drops to functional operation for one capture clock. From that point it repeatedly unloads the captured response while it shifts in the next stimulus during the same clocks, and it ends with a final unload. Stimuli and expected responses come from a small internal pattern store that is filled by a parameterised formula. A sticky flag records any miscompare.

The block has one serial input pin and one serial output pin, and both are shared. When test mode is off they carry functional data. When test mode is on they carry the chain input and the chain output. With test mode on and no sequence running, an external tester can shift the chain directly through the shared pins.

Top module: `scan_test_ctrl`

## Requirements
- R1: While `test_mode` is 0, every clock loads `present_state` from `func_next`, and `scan_en` is 0.
- R2: While `scan_en` is 1, every clock moves the chain one place: `present_state` becomes `{present_state[L-2:0], s}`, where s is the serial input bit. The bit leaving the chain, `present_state[L-1]`, appears on `pin_out` whenever `test_mode` is 1.
- R3: With `test_mode` 0, `core_in` equals `pin_in` and `pin_out` equals `core_out`. With `test_mode` 1, `core_in` is 0. When no sequence is running (idle, or finished), `pin_in` is the serial input of the chain.
- R4: A `run` pulse seen at a clock edge while `test_mode` is 1 and the sequencer is idle starts a sequence. `run` has no effect while `test_mode` is 0. The sequence begins with 2L shift clocks whose input bits are 1, 0, 1, 0 and so on, starting with 1. Bits L to 2L-1 of the output stream are compared with the bits sent L clocks earlier.
- R5: The next L shift clocks load stimulus 0, most significant bit first, so that stimulus bit k ends up in `present_state[k]`.
- R6: After each load the sequencer spends exactly one clock with `scan_en` 0, in which `present_state` takes `func_next`.
- R7: After each capture except the last, L shift clocks run. Each clock compares the outgoing bit with the expected response of that pattern, bit L-1 first, and in the same clock shifts in the next stimulus, bit L-1 first. After the last capture, L shift clocks compare the final response and shift in zeros.
- R8: Stimulus p is `(PAT_SEED + p*PAT_STEP) mod 2^L`. Its expected response is the stimulus rotated left by one place, so that result bit k is stimulus bit k-1 and result bit 0 is stimulus bit L-1, then XORed with `RESP_MASK`.
- R9: `fail` is set by any miscompare. It stays set until the next sequence starts or a reset occurs.
- R10: `done` rises when the final unload completes, exactly 3L + N(L+1) clocks after the start edge. It stays high while `test_mode` stays 1. Clearing `test_mode` at any time returns the sequencer to idle, and `done` is 0 from the following clock.
- R11: Reset (`rst_n` low) clears the chain, `done` and `fail`, and leaves the sequencer idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Selects the test regime |
| run | input | 1 | Starts the built-in sequence |
| pin_in | input | 1 | Shared pin: functional input or serial chain input |
| pin_out | output | 1 | Shared pin: functional output or chain output |
| core_in | output | 1 | Functional input passed to the core logic |
| core_out | input | 1 | Functional output coming from the core logic |
| func_next | input | CHAIN_LEN | Next-state vector from the combinational logic |
| present_state | output | CHAIN_LEN | Present-state vector to the combinational logic |
| scan_en | output | 1 | 1 while the chain shifts |
| done | output | 1 | Sequence finished |
| fail | output | 1 | Sticky miscompare flag |

## Verification
In the same shift clock the chain unloads the captured response of pattern k and loads the stimulus of pattern k+1. An error in either direction could therefore be hidden by the other. The bench provokes this overlap by running a full multi-pattern sequence against a combinational model that matches the expected-response formula. It judges the result from both sides: every bit leaving on `pin_out` is compared with the expected response, and `present_state` at the following capture clock must equal the next stimulus exactly. Runs with a single faulted next-state bit, swept over every bit position, show that the unload comparison catches responses that the overlapped load would otherwise overwrite.

// File: rtl/scan_pkg.sv
package scan_pkg;

   // Sequencer phases of the built-in scan test
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FLUSH,
      ST_LOAD,
      ST_CAPTURE,
      ST_UNLOAD_LOAD,
      ST_FINAL_UNLOAD,
      ST_DONE
   } scan_state_e;

endpackage

// File: rtl/scan_chain.sv
// Chain of flip-flops, each fed by a 2:1 selector (functional data or previous stage)
module scan_chain #(
   parameter int LEN = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           scan_si,
   input  logic [LEN-1:0] d_func,
   output logic [LEN-1:0] q,
   output logic           scan_so
);

   logic [LEN-1:0] link;

   assign link[0] = scan_si;

   for (genvar i = 0; i < LEN; i++) begin : g_cell
      if (i > 0) begin : g_link
         assign link[i] = q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= shift_en ? link[i] : d_func[i];
      end
   end

   assign scan_so = q[LEN-1];

endmodule

// File: rtl/scan_pattern_store.sv
// Stimulus / expected-response store; contents follow an arithmetic rule
module scan_pattern_store #(
   parameter int             LEN        = 8,
   parameter int             NPAT       = 4,
   parameter int             PW         = 2,
   parameter logic [LEN-1:0] SEED       = '0,
   parameter logic [LEN-1:0] STEP       = '0,
   parameter logic [LEN-1:0] MASK       = '0,
   parameter bit             TABLE_MODE = 1'b1
) (
   input  logic [PW-1:0]  stim_idx,
   input  logic [PW-1:0]  resp_idx,
   output logic [LEN-1:0] stim_vec,
   output logic [LEN-1:0] resp_vec
);

   function automatic logic [LEN-1:0] gen_stim(input logic [PW-1:0] k);
      return SEED + STEP * LEN'(k);
   endfunction

   function automatic logic [LEN-1:0] gen_resp(input logic [LEN-1:0] s);
      return {s[LEN-2:0], s[LEN-1]} ^ MASK;
   endfunction

   if (TABLE_MODE) begin : g_table
      logic [LEN-1:0] stim_tab [NPAT];
      logic [LEN-1:0] resp_tab [NPAT];
      for (genvar p = 0; p < NPAT; p++) begin : g_row
         assign stim_tab[p] = gen_stim(PW'(p));
         assign resp_tab[p] = gen_resp(gen_stim(PW'(p)));
      end
      assign stim_vec = stim_tab[stim_idx];
      assign resp_vec = resp_tab[resp_idx];
   end else begin : g_calc
      assign stim_vec = gen_stim(stim_idx);
      assign resp_vec = gen_resp(gen_stim(resp_idx));
   end

endmodule

// File: rtl/scan_seq.sv
// Sequencer: flush check, load, capture, overlapped unload/load, final unload
module scan_seq
   import scan_pkg::*;
#(
   parameter int LEN  = 8,
   parameter int NPAT = 4,
   parameter int PW   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           test_mode,
   input  logic           run,
   input  logic           scan_so,
   input  logic           pin_si,
   input  logic [LEN-1:0] stim_vec,
   input  logic [LEN-1:0] resp_vec,
   output logic [PW-1:0]  stim_idx,
   output logic [PW-1:0]  resp_idx,
   output logic           shift_en,
   output logic           chain_si,
   output logic           done,
   output logic           fail
);

   localparam int             CW         = $clog2(2 * LEN);
   localparam int             IW         = $clog2(LEN);
   localparam logic [CW-1:0]  FLUSH_LAST = CW'(2 * LEN - 1);
   localparam logic [CW-1:0]  SHIFT_LAST = CW'(LEN - 1);
   localparam logic [CW-1:0]  LEN_C      = CW'(LEN);
   localparam logic           LEN_ODD    = 1'((LEN % 2) == 1);
   localparam logic [PW-1:0]  PAT_LAST   = PW'(NPAT - 1);

   scan_state_e    state;
   logic [CW-1:0]  cnt;
   logic [PW-1:0]  pidx;
   logic [PW-1:0]  nxt_idx;
   logic [IW-1:0]  bit_pos;
   logic           cmp_en;
   logic           exp_bit;
   logic           mismatch;

   always_comb begin
      shift_en = test_mode && (state != ST_CAPTURE);
      bit_pos  = IW'(LEN - 1) - cnt[IW-1:0];
      nxt_idx  = (pidx == PAT_LAST) ? PAT_LAST : pidx + PW'(1);
      stim_idx = (state == ST_LOAD) ? '0 : nxt_idx;
      resp_idx = pidx;
      chain_si = 1'b0;
      cmp_en   = 1'b0;
      exp_bit  = 1'b0;
      unique case (state)
         ST_IDLE, ST_DONE: chain_si = pin_si;
         ST_FLUSH: begin
            chain_si = ~cnt[0];
            cmp_en   = (cnt >= LEN_C);
            exp_bit  = ~(cnt[0] ^ LEN_ODD);
         end
         ST_LOAD: chain_si = stim_vec[bit_pos];
         ST_UNLOAD_LOAD: begin
            chain_si = stim_vec[bit_pos];
            cmp_en   = 1'b1;
            exp_bit  = resp_vec[bit_pos];
         end
         ST_FINAL_UNLOAD: begin
            cmp_en   = 1'b1;
            exp_bit  = resp_vec[bit_pos];
         end
         default: chain_si = 1'b0;
      endcase
      mismatch = test_mode && cmp_en && (scan_so != exp_bit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         pidx  <= '0;
         fail  <= 1'b0;
      end else if (!test_mode) begin
         state <= ST_IDLE;
         cnt   <= '0;
         pidx  <= '0;
      end else begin
         if (mismatch) fail <= 1'b1;
         unique case (state)
            ST_IDLE: if (run) begin
               state <= ST_FLUSH;
               cnt   <= '0;
               pidx  <= '0;
               fail  <= 1'b0;
            end
            ST_FLUSH: begin
               if (cnt == FLUSH_LAST) begin
                  state <= ST_LOAD;
                  cnt   <= '0;
               end else cnt <= cnt + CW'(1);
            end
            ST_LOAD: begin
               if (cnt == SHIFT_LAST) begin
                  state <= ST_CAPTURE;
                  cnt   <= '0;
               end else cnt <= cnt + CW'(1);
            end
            ST_CAPTURE: begin
               state <= (pidx == PAT_LAST) ? ST_FINAL_UNLOAD : ST_UNLOAD_LOAD;
               cnt   <= '0;
            end
            ST_UNLOAD_LOAD: begin
               if (cnt == SHIFT_LAST) begin
                  state <= ST_CAPTURE;
                  cnt   <= '0;
                  pidx  <= nxt_idx;
               end else cnt <= cnt + CW'(1);
            end
            ST_FINAL_UNLOAD: begin
               if (cnt == SHIFT_LAST) begin
                  state <= ST_DONE;
                  cnt   <= '0;
               end else cnt <= cnt + CW'(1);
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   assign done = (state == ST_DONE);

endmodule

// File: rtl/scan_test_ctrl.sv
// Top: scan chain, pattern store, sequencer and shared-pin steering
module scan_test_ctrl #(
   parameter int                   CHAIN_LEN  = 8,
   parameter int                   NUM_PAT    = 4,
   parameter logic [CHAIN_LEN-1:0] PAT_SEED   = CHAIN_LEN'(165),
   parameter logic [CHAIN_LEN-1:0] PAT_STEP   = CHAIN_LEN'(59),
   parameter logic [CHAIN_LEN-1:0] RESP_MASK  = CHAIN_LEN'(90),
   parameter bit                   TABLE_MODE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 test_mode,
   input  logic                 run,
   input  logic                 pin_in,
   output logic                 pin_out,
   output logic                 core_in,
   input  logic                 core_out,
   input  logic [CHAIN_LEN-1:0] func_next,
   output logic [CHAIN_LEN-1:0] present_state,
   output logic                 scan_en,
   output logic                 done,
   output logic                 fail
);

   localparam int PW = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;

   if (CHAIN_LEN < 2) begin : g_bad_len
      $error("scan_test_ctrl: CHAIN_LEN must be at least 2");
   end
   if (NUM_PAT < 1 || NUM_PAT > 256) begin : g_bad_npat
      $error("scan_test_ctrl: NUM_PAT must lie in 1..256");
   end

   logic                 chain_si;
   logic                 scan_so;
   logic [PW-1:0]        stim_idx;
   logic [PW-1:0]        resp_idx;
   logic [CHAIN_LEN-1:0] stim_vec;
   logic [CHAIN_LEN-1:0] resp_vec;

   scan_seq #(
      .LEN  (CHAIN_LEN),
      .NPAT (NUM_PAT),
      .PW   (PW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .test_mode (test_mode),
      .run       (run),
      .scan_so   (scan_so),
      .pin_si    (pin_in),
      .stim_vec  (stim_vec),
      .resp_vec  (resp_vec),
      .stim_idx  (stim_idx),
      .resp_idx  (resp_idx),
      .shift_en  (scan_en),
      .chain_si  (chain_si),
      .done      (done),
      .fail      (fail)
   );

   scan_pattern_store #(
      .LEN        (CHAIN_LEN),
      .NPAT       (NUM_PAT),
      .PW         (PW),
      .SEED       (PAT_SEED),
      .STEP       (PAT_STEP),
      .MASK       (RESP_MASK),
      .TABLE_MODE (TABLE_MODE)
   ) u_store (
      .stim_idx (stim_idx),
      .resp_idx (resp_idx),
      .stim_vec (stim_vec),
      .resp_vec (resp_vec)
   );

   scan_chain #(
      .LEN (CHAIN_LEN)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (scan_en),
      .scan_si  (chain_si),
      .d_func   (func_next),
      .q        (present_state),
      .scan_so  (scan_so)
   );

   // Shared pins: functional data when test_mode is 0, chain data when 1
   assign pin_out = test_mode ? scan_so : core_out;
   assign core_in = test_mode ? 1'b0 : pin_in;

endmodule

// File: rtl/scan_test_ctrl_chk.sv
// Protocol checker bound to the top module
module scan_test_ctrl_chk #(
   parameter int LEN = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           test_mode,
   input logic           run,
   input logic           scan_en,
   input logic           chain_si,
   input logic           done,
   input logic           fail,
   input logic [LEN-1:0] present_state,
   input logic [LEN-1:0] func_next
);

   assert_func_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode) |=> (present_state == $past(func_next)));

   assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> (present_state == {$past(present_state[LEN-2:0]), $past(chain_si)}));

   assert_capture_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && !scan_en) |=> (scan_en || !test_mode));

   assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !run) |=> fail);

   assert_done_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode) |=> !done);

endmodule

bind scan_test_ctrl scan_test_ctrl_chk #(.LEN(CHAIN_LEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .test_mode     (test_mode),
   .run           (run),
   .scan_en       (scan_en),
   .chain_si      (chain_si),
   .done          (done),
   .fail          (fail),
   .present_state (present_state),
   .func_next     (func_next)
);

// File: tb/tb_scan_test_ctrl.sv
module tb_scan_test_ctrl;

   localparam int          CLK_PERIOD = 10;
   localparam int          L     = 6;
   localparam int          N     = 5;
   localparam logic [L-1:0] SEED = 6'h2D;
   localparam logic [L-1:0] STEP = 6'h13;
   localparam logic [L-1:0] MASK = 6'h15;
   localparam int          TOTAL = 3 * L + N * (L + 1);

   logic         clk = 1'b0;
   logic         rst_n, test_mode, run, pin_in, core_out;
   logic [L-1:0] fault_vec;
   logic         pin_out, core_in, scan_en, done, fail;
   logic [L-1:0] present_state, func_next;
   int           n_checks = 0;
   int           n_fail   = 0;
   bit           finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // Combinational model of the core logic: rotate-left-by-one XOR mask, plus injected fault
   assign func_next = {present_state[L-2:0], present_state[L-1]} ^ MASK ^ fault_vec;

   scan_test_ctrl #(
      .CHAIN_LEN (L),
      .NUM_PAT   (N),
      .PAT_SEED  (SEED),
      .PAT_STEP  (STEP),
      .RESP_MASK (MASK)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .test_mode     (test_mode),
      .run           (run),
      .pin_in        (pin_in),
      .pin_out       (pin_out),
      .core_in       (core_in),
      .core_out      (core_out),
      .func_next     (func_next),
      .present_state (present_state),
      .scan_en       (scan_en),
      .done          (done),
      .fail          (fail)
   );

   function automatic logic [L-1:0] stim_f(input int p);
      return SEED + STEP * L'(p);
   endfunction

   function automatic logic [L-1:0] resp_f(input int p);
      logic [L-1:0] s;
      s = stim_f(p);
      return {s[L-2:0], s[L-1]} ^ MASK;
   endfunction

   function automatic logic [L-1:0] nxt_f(input logic [L-1:0] s);
      return {s[L-2:0], s[L-1]} ^ MASK;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Run one full built-in sequence; bit-level checks only when the core model is fault-free
   task automatic do_run(input bit checked);
      @(negedge clk) run = 1'b1;
      @(negedge clk) run = 1'b0;
      for (int t = 0; t <= TOTAL; t++) begin
         if (t < 2 * L) begin
            if (t == 0) chk(scan_en == 1'b1, "R4 flush shifts", scan_en, 1);
            if (checked && t >= L)
               chk(pin_out == ((t - L) % 2 == 0), "R4 flush stream", pin_out, ((t - L) % 2 == 0));
         end else if (t >= 3 * L && t < TOTAL) begin
            int u = t - 3 * L;
            int k = u / (L + 1);
            int j = u % (L + 1);
            if (j == 0) begin
               chk(scan_en == 1'b0, "R6 capture clock", scan_en, 0);
               if (checked)
                  chk(present_state == stim_f(k), (k == 0) ? "R5 R8 loaded stimulus" : "R7 R8 overlapped load",
                      present_state, stim_f(k));
            end else begin
               chk(scan_en == 1'b1, "R6 single capture", scan_en, 1);
               if (checked && j == 1)
                  chk(present_state == resp_f(k), "R6 R8 captured response", present_state, resp_f(k));
               if (checked)
                  chk(pin_out == resp_f(k)[L - j], "R7 unload bit", pin_out, resp_f(k)[L - j]);
            end
         end else if (t == TOTAL) begin
            chk(done == 1'b1, "R10 done after final unload", done, 1);
            if (checked) chk(present_state == '0, "R7 final unload zero fill", present_state, 0);
         end
         if (t < TOTAL) @(negedge clk);
      end
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [L-1:0] expv;
      logic [L-1:0] prevv;
      rst_n = 1'b0; test_mode = 1'b0; run = 1'b0; pin_in = 1'b0; core_out = 1'b0; fault_vec = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(present_state == '0, "R11 reset chain", present_state, 0);
      chk(done == 1'b0, "R11 reset done", done, 0);
      chk(fail == 1'b0, "R11 reset fail", fail, 0);
      rst_n = 1'b1;

      // R1 functional loading
      expv = '0;
      for (int c = 0; c < 2 * L; c++) begin
         expv = nxt_f(expv);
         @(negedge clk);
         chk(present_state == expv, "R1 functional load", present_state, expv);
         chk(scan_en == 1'b0, "R1 no shift", scan_en, 0);
      end

      // R3 shared pins in functional mode
      for (int a = 0; a < 2; a++) begin
         for (int b = 0; b < 2; b++) begin
            pin_in = a[0]; core_out = b[0];
            #1;
            chk(core_in == a[0], "R3 pin_in to core_in", core_in, a);
            chk(pin_out == b[0], "R3 core_out to pin_out", pin_out, b);
         end
      end

      // R2 R3 manual shift through shared pins, all chain values
      @(negedge clk);
      test_mode = 1'b1; pin_in = 1'b1; core_out = 1'b1;
      #1;
      chk(core_in == 1'b0, "R3 core_in blocked in test", core_in, 0);
      prevv = present_state;
      for (int v = 0; v < (1 << L); v++) begin
         for (int i = 0; i < L; i++) begin
            chk(pin_out == prevv[L-1-i], "R2 shift out on pin", pin_out, prevv[L-1-i]);
            pin_in = v[L-1-i];
            @(negedge clk);
         end
         chk(present_state == L'(v), "R2 shift in from pin", present_state, v);
         prevv = L'(v);
      end
      pin_in = 1'b0;

      // Good sequence
      do_run(1'b1);
      chk(fail == 1'b0, "R9 no miscompare", fail, 0);
      repeat (5) @(negedge clk);
      chk(done == 1'b1, "R10 done holds", done, 1);
      test_mode = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R10 done cleared by mode", done, 0);

      // R9 single-bit fault sweep
      for (int b = 0; b < L; b++) begin
         fault_vec = L'(1) << b;
         test_mode = 1'b1;
         do_run(1'b0);
         chk(fail == 1'b1, "R9 fault detected", fail, 1);
         @(negedge clk) test_mode = 1'b0; fault_vec = '0;
         @(negedge clk);
         chk(fail == 1'b1, "R9 fail sticky", fail, 1);
      end

      // R9 fail cleared by a new start
      test_mode = 1'b1;
      do_run(1'b1);
      chk(fail == 1'b0, "R9 cleared on start", fail, 0);

      // R10 abort mid-flush, then R1 resumes
      @(negedge clk) test_mode = 1'b0;
      @(negedge clk) test_mode = 1'b1; run = 1'b1;
      @(negedge clk) run = 1'b0;
      repeat (4) @(negedge clk);
      test_mode = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R10 abort done low", done, 0);
      chk(scan_en == 1'b0, "R10 abort no shift", scan_en, 0);
      prevv = present_state;
      @(negedge clk);
      chk(present_state == nxt_f(prevv), "R1 after abort", present_state, nxt_f(prevv));
      test_mode = 1'b1;
      do_run(1'b1);
      chk(fail == 1'b0, "R10 rerun after abort", fail, 0);

      // R4 run ignored without test mode
      @(negedge clk) test_mode = 1'b0; run = 1'b1;
      repeat (3) @(negedge clk);
      run = 1'b0; test_mode = 1'b1; pin_in = 1'b0;
      repeat (TOTAL + 5) @(negedge clk);
      chk(done == 1'b0, "R4 run ignored in functional mode", done, 0);
      chk(present_state == '0, "R4 chain under manual shift", present_state, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule